// File: doc/BRIEF.md
# Asynchronous Read Handshake Controller

This block holds both ends of an unclocked read handshake on a shared address/data path. A device-side requester takes a read address, places it on the shared lines and raises a request strobe. A memory-side responder latches the address, acknowledges it, waits a programmable number of cycles and returns a data word on the same lines under a data-ready strobe. The device side then acknowledges the data. Every step is fully interlocked: each side changes a line only after it has observed the other side's previous change. This means neither side relies on the other's timing.

Each side sees the other side's strobes only through a two-flop synchronizer. The shared lines are modelled as a drive-enable and a value per side, merged into one observable bus. The acknowledge line has one driver per side, and both drivers are brought out. The requester reports a busy level and a one-cycle done pulse. It also raises a one-cycle timeout error if an awaited strobe edge does not arrive within a configured number of cycles. The responder's data source is a small computed read-only table.

Top module: `rdhs_link_top`

## Requirements
- R1: After reset, every strobe, both drive enables, the shared bus value, `busy`, `done`, `timeout_err` and `rd_data` are all 0.
- R2: When `start` is sampled high in idle, the requester raises `line_req` and `drv_dev` on the same edge and drives `rd_addr`, zero-extended, onto `line_dat`.
- R3: The responder latches the address and raises `line_mem_ack` 3 cycles after the request rises: two synchronizer flops and one state register.
- R4: The requester drops `line_req` and `drv_dev` 3 cycles after `line_mem_ack` rises.
- R5: The responder drops `line_mem_ack` 3 cycles after the request falls. It then waits `ready_delay` cycles, where 0 is allowed, and on the next edge raises `line_rdy` and `drv_mem`.
- R6: The returned word for address a is the low `DATA_W` bits of (a × 0x1357) XOR 0xC0DE. The requester copies it into `rd_data` on the edge on which it raises `line_dev_ack`.
- R7: The requester raises `line_dev_ack` 3 cycles after `line_rdy` rises. The responder drops `line_rdy` and `drv_mem` 3 cycles after that.
- R8: The requester drops `line_dev_ack` 3 cycles after `line_rdy` falls. On that edge, `done` pulses for one cycle and `busy` goes low; `busy` is high from the start edge until then.
- R9: `drv_dev` and `drv_mem` are never high in the same cycle.
- R10: While waiting for a strobe edge, the requester counts cycles. If the edge has not arrived when the count equals `wait_limit`, the requester pulses `timeout_err`, releases all its lines, returns to idle and leaves `rd_data` unchanged. If the edge arrives on that same cycle, the edge wins.
- R11: A `start` pulse while `busy` is high is ignored: it changes no line, no timing and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read (taken only when idle) |
| rd_addr | input | ADDR_W | Read address |
| ready_delay | input | DLY_W | Responder cycles between address release and data-ready |
| wait_limit | input | TMO_W | Requester wait limit per awaited edge |
| busy | output | 1 | Requester transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last word read |
| timeout_err | output | 1 | One-cycle timeout pulse |
| line_req | output | 1 | Request strobe |
| line_mem_ack | output | 1 | Acknowledge driven by the responder |
| line_dev_ack | output | 1 | Acknowledge driven by the requester |
| line_rdy | output | 1 | Data-ready strobe |
| line_dat | output | DATA_W | Merged value of the shared lines (0 when undriven) |
| drv_dev | output | 1 | Requester drives the shared lines |
| drv_mem | output | 1 | Responder drives the shared lines |

## Verification
Two functions can act in the same cycle: the wait-limit counter reaching its limit, and the synchronized data-ready edge arriving. The bench provokes this with a ready delay of 14 and a limit of 20, so that the edge lands on exactly the cycle in which the count equals the limit. It checks that the transfer completes normally. A delay of 15 with the same limit must instead give a timeout pulse on a predicted cycle. A second overlap is a `start` pulse that arrives mid-transaction while the responder is holding its acknowledge; the bench judges it against a model that ignores that pulse.

// File: rtl/rdhs_pkg.sv
package rdhs_pkg;

    typedef enum logic [1:0] {
        RQ_IDLE,
        RQ_ADDR,
        RQ_WDAT,
        RQ_FIN
    } rq_state_e;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_ACKD,
        RS_WAIT,
        RS_SEND,
        RS_DRAIN
    } rs_state_e;

    localparam logic [31:0] ROM_MUL = 32'h0000_1357;
    localparam logic [31:0] ROM_XOR = 32'h0000_C0DE;

endpackage

// File: rtl/rdhs_sync.sv
module rdhs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rdhs_requester.sv
module rdhs_requester
    import rdhs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [TMO_W-1:0]  tmo_i,
    input  logic              s_ack_i,
    input  logic              s_rdy_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              req_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] val_o,
    output logic              ack_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdat_o
);
    typedef struct packed {
        rq_state_e         st;
        logic              req;
        logic              oe;
        logic [DATA_W-1:0] val;
        logic              ack;
        logic [DATA_W-1:0] rdat;
        logic              done;
        logic              err;
        logic [TMO_W-1:0]  wcnt;
    } rq_reg_t;

    rq_reg_t r_d, r_q;
    logic    abort;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        abort    = 1'b0;
        unique case (r_q.st)
            RQ_IDLE: begin
                if (start_i) begin
                    r_d.st   = RQ_ADDR;
                    r_d.req  = 1'b1;
                    r_d.oe   = 1'b1;
                    r_d.val  = DATA_W'(addr_i);
                    r_d.wcnt = '0;
                end
            end
            RQ_ADDR: begin
                if (s_ack_i) begin
                    r_d.st   = RQ_WDAT;
                    r_d.req  = 1'b0;
                    r_d.oe   = 1'b0;
                    r_d.val  = '0;
                    r_d.wcnt = '0;
                end else if (r_q.wcnt == tmo_i) begin
                    abort = 1'b1;
                end else begin
                    r_d.wcnt = r_q.wcnt + 1'b1;
                end
            end
            RQ_WDAT: begin
                if (s_rdy_i) begin
                    r_d.st   = RQ_FIN;
                    r_d.rdat = bus_i;
                    r_d.ack  = 1'b1;
                    r_d.wcnt = '0;
                end else if (r_q.wcnt == tmo_i) begin
                    abort = 1'b1;
                end else begin
                    r_d.wcnt = r_q.wcnt + 1'b1;
                end
            end
            RQ_FIN: begin
                if (!s_rdy_i) begin
                    r_d.st   = RQ_IDLE;
                    r_d.ack  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.wcnt = '0;
                end else if (r_q.wcnt == tmo_i) begin
                    abort = 1'b1;
                end else begin
                    r_d.wcnt = r_q.wcnt + 1'b1;
                end
            end
            default: r_d.st = RQ_IDLE;
        endcase
        if (abort) begin
            r_d.st   = RQ_IDLE;
            r_d.req  = 1'b0;
            r_d.oe   = 1'b0;
            r_d.val  = '0;
            r_d.ack  = 1'b0;
            r_d.err  = 1'b1;
            r_d.wcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RQ_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign req_o  = r_q.req;
    assign oe_o   = r_q.oe;
    assign val_o  = r_q.val;
    assign ack_o  = r_q.ack;
    assign busy_o = (r_q.st != RQ_IDLE);
    assign done_o = r_q.done;
    assign err_o  = r_q.err;
    assign rdat_o = r_q.rdat;

    // The request may fall only after the synchronized acknowledge was seen, or on a timeout.
    assert_req_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.req) |-> ($past(s_ack_i) || r_q.err));
endmodule

// File: rtl/rdhs_responder.sv
module rdhs_responder
    import rdhs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DLY_W-1:0]  dly_i,
    input  logic              s_req_i,
    input  logic              s_ack_i,
    input  logic [ADDR_W-1:0] addr_bus_i,
    output logic              ack_o,
    output logic              rdy_o,
    output logic              oe_o,
    output logic [DATA_W-1:0] val_o
);
    typedef struct packed {
        rs_state_e         st;
        logic              ack;
        logic              rdy;
        logic              oe;
        logic [DATA_W-1:0] val;
        logic [ADDR_W-1:0] addr;
        logic [DLY_W-1:0]  cnt;
    } rs_reg_t;

    rs_reg_t r_d, r_q;

    function automatic logic [DATA_W-1:0] rom_word(input logic [ADDR_W-1:0] a);
        return DATA_W'((32'(a) * ROM_MUL) ^ ROM_XOR);
    endfunction

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            RS_IDLE: begin
                if (s_req_i) begin
                    r_d.st   = RS_ACKD;
                    r_d.addr = addr_bus_i;
                    r_d.ack  = 1'b1;
                end
            end
            RS_ACKD: begin
                if (!s_req_i) begin
                    r_d.st  = RS_WAIT;
                    r_d.ack = 1'b0;
                    r_d.cnt = '0;
                end
            end
            RS_WAIT: begin
                if (r_q.cnt == dly_i) begin
                    r_d.st  = RS_SEND;
                    r_d.oe  = 1'b1;
                    r_d.val = rom_word(r_q.addr);
                    r_d.rdy = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            RS_SEND: begin
                if (s_ack_i) begin
                    r_d.st  = RS_DRAIN;
                    r_d.rdy = 1'b0;
                    r_d.oe  = 1'b0;
                    r_d.val = '0;
                end
            end
            RS_DRAIN: begin
                if (!s_ack_i) r_d.st = RS_IDLE;
            end
            default: r_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RS_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign ack_o = r_q.ack;
    assign rdy_o = r_q.rdy;
    assign oe_o  = r_q.oe;
    assign val_o = r_q.val;

    // Data-ready may fall only after the synchronized device acknowledge was seen.
    assert_rdy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.rdy) |-> $past(s_ack_i));
endmodule

// File: rtl/rdhs_link_top.sv
module rdhs_link_top
    import rdhs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int DLY_W  = 8,
    parameter int TMO_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DLY_W-1:0]  ready_delay,
    input  logic [TMO_W-1:0]  wait_limit,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              timeout_err,
    output logic              line_req,
    output logic              line_mem_ack,
    output logic              line_dev_ack,
    output logic              line_rdy,
    output logic [DATA_W-1:0] line_dat,
    output logic              drv_dev,
    output logic              drv_mem
);
    localparam int CTRL_W = 2;

    logic [DATA_W-1:0] dev_val, mem_val, bus_w;
    logic [CTRL_W-1:0] to_dev_s, to_mem_s;

    assign bus_w = (drv_dev ? dev_val : '0) | (drv_mem ? mem_val : '0);

    rdhs_sync #(.W(CTRL_W), .STAGES(SYNC_N)) u_sync_dev (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({line_mem_ack, line_rdy}),
        .q_o   (to_dev_s)
    );

    rdhs_sync #(.W(CTRL_W), .STAGES(SYNC_N)) u_sync_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({line_req, line_dev_ack}),
        .q_o   (to_mem_s)
    );

    rdhs_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TMO_W(TMO_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .addr_i  (rd_addr),
        .tmo_i   (wait_limit),
        .s_ack_i (to_dev_s[1]),
        .s_rdy_i (to_dev_s[0]),
        .bus_i   (bus_w),
        .req_o   (line_req),
        .oe_o    (drv_dev),
        .val_o   (dev_val),
        .ack_o   (line_dev_ack),
        .busy_o  (busy),
        .done_o  (done),
        .err_o   (timeout_err),
        .rdat_o  (rd_data)
    );

    rdhs_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W)) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .dly_i      (ready_delay),
        .s_req_i    (to_mem_s[1]),
        .s_ack_i    (to_mem_s[0]),
        .addr_bus_i (bus_w[ADDR_W-1:0]),
        .ack_o      (line_mem_ack),
        .rdy_o      (line_rdy),
        .oe_o       (drv_mem),
        .val_o      (mem_val)
    );

    assign line_dat = bus_w;

    assert_single_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_dev && drv_mem));

    assert_ack_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_mem_ack) |-> line_req);

    assert_ack_drop_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_mem_ack) |-> !line_req);

    assert_rdy_after_addr_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_rdy) |-> (!line_mem_ack && !line_req));

    assert_dev_ack_needs_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_dev_ack) |-> line_rdy);

    assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !line_dev_ack && !line_rdy));
endmodule

// File: tb/rdhs_link_tb_top.sv
module rdhs_link_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  ready_delay = '0;
    logic [7:0]  wait_limit = 8'd200;
    logic        busy, done, timeout_err;
    logic [15:0] rd_data, line_dat;
    logic        line_req, line_mem_ack, line_dev_ack, line_rdy, drv_dev, drv_mem;

    int errs = 0;
    int checks = 0;
    logic [15:0] prev_rd = '0;

    always #10 clk = ~clk;

    rdhs_link_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .rd_addr      (rd_addr),
        .ready_delay  (ready_delay),
        .wait_limit   (wait_limit),
        .busy         (busy),
        .done         (done),
        .rd_data      (rd_data),
        .timeout_err  (timeout_err),
        .line_req     (line_req),
        .line_mem_ack (line_mem_ack),
        .line_dev_ack (line_dev_ack),
        .line_rdy     (line_rdy),
        .line_dat     (line_dat),
        .drv_dev      (drv_dev),
        .drv_mem      (drv_mem)
    );

    function automatic logic [15:0] rom(input int a);
        return 16'((32'(a) * 32'h1357) ^ 32'hC0DE);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(line_req == 0 && line_mem_ack == 0 && line_dev_ack == 0 && line_rdy == 0,
            {tag, " strobes"}, {line_req, line_mem_ack, line_dev_ack, line_rdy}, 0);
        chk(drv_dev == 0 && drv_mem == 0 && line_dat == 0, {tag, " bus"}, line_dat, 0);
        chk(busy == 0 && done == 0 && timeout_err == 0, {tag, " status"},
            {busy, done, timeout_err}, 0);
        chk(rd_data == 0, {tag, " rd_data"}, rd_data, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        prev_rd = '0;
    endtask

    // Behavioural timeline: k counts edges after the edge that sampled start.
    task automatic run_txn(input int a, input int d, input int lim, input bit tmo, input bit poke);
        int kend;
        int kt;
        kt = 7 + lim;
        kend = tmo ? kt + 3 : 20 + d;
        @(negedge clk);
        rd_addr = 4'(a);
        ready_delay = 8'(d);
        wait_limit = 8'(lim);
        start = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= kend; k++) begin
            bit e_req, e_mack, e_rdy, e_dack, e_busy, e_done, e_err;
            logic [15:0] e_dat, e_rd;
            @(negedge clk);
            if (k == 0) start = 1'b0;
            if (poke && k == 4) begin start = 1'b1; rd_addr = 4'(a ^ 9); end
            if (poke && k == 5) begin start = 1'b0; rd_addr = 4'(a); end
            e_req  = (k <= 5);
            e_mack = (k >= 3 && k <= 8);
            e_rdy  = tmo ? (k >= 10 + d) : (k >= 10 + d && k <= 15 + d);
            e_dack = !tmo && (k >= 13 + d && k <= 18 + d);
            e_busy = tmo ? (k < kt) : (k <= 18 + d);
            e_done = !tmo && (k == 19 + d);
            e_err  = tmo && (k == kt);
            e_dat  = e_req ? 16'(a) : (e_rdy ? rom(a) : 16'h0);
            e_rd   = (!tmo && k >= 13 + d) ? rom(a) : prev_rd;
            chk(line_req == e_req && drv_dev == e_req, "R2 R4 request/drive", {line_req, drv_dev}, {e_req, e_req});
            chk(line_mem_ack == e_mack, "R3 responder ack", line_mem_ack, e_mack);
            chk(line_rdy == e_rdy && drv_mem == e_rdy, "R5 data-ready/drive", {line_rdy, drv_mem}, {e_rdy, e_rdy});
            chk(line_dev_ack == e_dack, "R7 device ack", line_dev_ack, e_dack);
            chk(line_dat == e_dat, "R6 shared bus value", line_dat, e_dat);
            chk(rd_data == e_rd, "R6 captured word", rd_data, e_rd);
            chk(busy == e_busy && done == e_done, "R8 busy/done", {busy, done}, {e_busy, e_done});
            chk(timeout_err == e_err, "R10 timeout pulse", timeout_err, e_err);
            chk(!(drv_dev && drv_mem), "R9 single driver", {drv_dev, drv_mem}, 0);
        end
        if (!tmo) prev_rd = rom(a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        check_idle("R1 after reset");

        run_txn(3, 0, 200, 0, 0);      // zero delay
        run_txn(15, 5, 200, 0, 0);     // top address, mid delay
        run_txn(0, 1, 200, 0, 1);      // start poked mid-transaction: R11
        chk(rd_data == rom(0), "R11 ignored start keeps result", rd_data, rom(0));
        run_txn(10, 14, 20, 0, 0);     // R10 edge arrives exactly at the limit
        run_txn(6, 3, 200, 0, 0);      // back-to-back after previous
        run_txn(12, 15, 20, 1, 0);     // R10 timeout one cycle past the limit

        do_reset();
        check_idle("R1 after second reset");
        run_txn(5, 2, 200, 0, 0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule